// File: doc/BRIEF.md
# Overlapping Serial Pattern Detector

The detector watches a serial bit stream that delivers one bit per clock and raises a flag whenever the three most recent bits read 1, 1, 0 in arrival order. The window slides by one bit each cycle, so every bit starts a new window that shares two bits with the one before it. Consecutive or interleaved occurrences are each reported. The stream is never cut into separate groups of three.

Two build-time choices shape the block. The output style selects between a registered flag and an early flag. The registered flag is high for the cycle in which the held history equals 1,1,0. The early flag is a combinational flag that is high in the cycle where a held 1,1 meets an incoming 0. The holding encoding selects between two ways of keeping state. One is a raw three-bit shift history. The other is a four-state progress tracker with the states nothing, one 1, two 1s, and hit. All four combinations show the same behaviour at the ports. Reset is asynchronous and active low. It empties the held history.

Top module: `seqdet_top`

## Requirements
- R1: While reset is low, and after it is released, the held history is all zeros. A 1,1,0 must therefore be built entirely from bits clocked in after the release. Any partial match in progress when reset is asserted is discarded.
- R2: Each new bit enters at the newest end of the history. A stream 0,1,1 does not match, and neither does any other order than 1,1,0.
- R3: With the registered style (OUT_STYLE = OUT_REGISTERED), match_o is 1 for exactly the cycle after the clock edge that accepted the final 0 of a 1,1,0. It is 0 in every other cycle.
- R4: With the early style (OUT_STYLE = OUT_EARLY), match_o is 1 in a cycle exactly when the last two accepted bits are 1,1 and bit_i is 0 in that cycle.
- R5: Windows overlap by two bits. 1,1,0,1,1,0 gives two matches, and 1,1,1,0 gives one match on its final 0.
- R6: For the same stream, the registered flag equals the early flag of the previous cycle, that is, it is delayed by exactly one clock.
- R7: The shift encoding (HOLD_ENC = HOLD_SHIFT) and the progress encoding (HOLD_ENC = HOLD_PROGRESS) give identical match_o sequences for any input stream.
- R8: In the progress encoding, a 1 received right after a hit counts as the first 1 of a new pattern. A run of three or more 1s keeps the two-1s state, so 1,1,0,1,1,0 and 1,1,1,1,0 each match on their final 0, while 1,1,0,1,0 matches only once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one stream bit is accepted per rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, clears the history |
| bit_i | input | 1 | Serial stream bit |
| match_o | output | 1 | Pattern flag, timing set by OUT_STYLE |

## Verification
The hardest case to reach from the ports is a partial match that is cut off by reset. The history must already hold 1,1 when reset is asserted, and the next bit after the release must be the 0 that would have completed the pattern. The stimulus sends 1,1, pulses reset at a falling edge, and then sends 0. It expects silence on every variant. Dense overlap is covered by back-to-back patterns and long runs of 1s. A pseudo-random stream then compares all four build variants with a sliding-window model, including the one-cycle lag between the two styles.

// File: rtl/seqdet_pkg.sv
`timescale 1ns/1ps
package seqdet_pkg;
  typedef enum logic {OUT_REGISTERED, OUT_EARLY} out_style_e;
  typedef enum logic {HOLD_SHIFT, HOLD_PROGRESS} hold_enc_e;

  localparam int unsigned WIN_LEN = 3;
  localparam logic [WIN_LEN-1:0] TARGET = 3'b110;  // oldest bit in MSB

  typedef enum logic [1:0] {PR_NONE, PR_ONE, PR_TWO, PR_HIT} prog_e;
endpackage

// File: rtl/seqdet_shift_core.sv
`timescale 1ns/1ps
module seqdet_shift_core
  import seqdet_pkg::*;
#(
  parameter out_style_e STYLE = OUT_REGISTERED
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic hit_o
);
  logic [WIN_LEN-1:0] hist_q;
  logic [WIN_LEN-1:0] hist_d;

  assign hist_d = {hist_q[WIN_LEN-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= '0;
    else         hist_q <= hist_d;
  end

  generate
    if (STYLE == OUT_REGISTERED) begin : g_reg
      assign hit_o = (hist_q == TARGET);
    end else begin : g_early
      assign hit_o = (hist_d == TARGET);
    end
  endgenerate

  // two newest bits of a hit become the two oldest of the next window
  AST_HIST_SLIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_q == TARGET) |=> (hist_q[WIN_LEN-1:1] == TARGET[WIN_LEN-2:0])); // R5
endmodule

// File: rtl/seqdet_prog_core.sv
`timescale 1ns/1ps
module seqdet_prog_core
  import seqdet_pkg::*;
#(
  parameter out_style_e STYLE = OUT_REGISTERED
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic hit_o
);
  prog_e state_q, state_d;

  always_comb begin
    state_d = PR_NONE;
    unique case (state_q)
      PR_NONE: state_d = bit_i ? PR_ONE : PR_NONE;
      PR_ONE:  state_d = bit_i ? PR_TWO : PR_NONE;
      PR_TWO:  state_d = bit_i ? PR_TWO : PR_HIT;
      PR_HIT:  state_d = bit_i ? PR_ONE : PR_NONE;
      default: state_d = PR_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= PR_NONE;
    else         state_q <= state_d;
  end

  generate
    if (STYLE == OUT_REGISTERED) begin : g_reg
      assign hit_o = (state_q == PR_HIT);
    end else begin : g_early
      assign hit_o = (state_q == PR_TWO) && !bit_i;
    end
  endgenerate

  AST_HIT_LEAVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PR_HIT) |=> (state_q != PR_HIT)); // R8
  AST_RUN_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == PR_TWO && bit_i) |=> (state_q == PR_TWO)); // R8
endmodule

// File: rtl/seqdet_top.sv
`timescale 1ns/1ps
module seqdet_top
  import seqdet_pkg::*;
#(
  parameter out_style_e OUT_STYLE = OUT_REGISTERED,
  parameter hold_enc_e  HOLD_ENC  = HOLD_SHIFT
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_i,
  output logic match_o
);
  generate
    if (HOLD_ENC == HOLD_SHIFT) begin : g_shift
      seqdet_shift_core #(.STYLE(OUT_STYLE)) u_core (
        .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .hit_o(match_o));
    end else begin : g_prog
      seqdet_prog_core #(.STYLE(OUT_STYLE)) u_core (
        .clk_i(clk_i), .rst_ni(rst_ni), .bit_i(bit_i), .hit_o(match_o));
    end
  endgenerate

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !match_o); // R1

  generate
    if (OUT_STYLE == OUT_REGISTERED) begin : g_chk_reg
      AST_REG_AFTER_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> !$past(bit_i)); // R3
      AST_REG_NO_BACK2BACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |=> !match_o); // R5
    end else begin : g_chk_early
      AST_EARLY_ZERO_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> !bit_i); // R4
      AST_EARLY_TWO_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        match_o |-> ($past(bit_i) && $past(bit_i, 2))); // R4
    end
  endgenerate
endmodule

// File: tb/seqdet_top_test.sv
`timescale 1ns/1ps
module seqdet_top_test;
  import seqdet_pkg::*;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic bit_i = 1'b0;
  logic m_sh_reg, m_sh_early, m_pg_reg, m_pg_early;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  seqdet_top #(.OUT_STYLE(OUT_REGISTERED), .HOLD_ENC(HOLD_SHIFT)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .match_o(m_sh_reg));
  seqdet_top #(.OUT_STYLE(OUT_EARLY), .HOLD_ENC(HOLD_SHIFT)) uut_sh_early (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .match_o(m_sh_early));
  seqdet_top #(.OUT_STYLE(OUT_REGISTERED), .HOLD_ENC(HOLD_PROGRESS)) uut_pg_reg (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .match_o(m_pg_reg));
  seqdet_top #(.OUT_STYLE(OUT_EARLY), .HOLD_ENC(HOLD_PROGRESS)) uut_pg_early (
    .clk_i(clk), .rst_ni(rst_ni), .bit_i(bit_i), .match_o(m_pg_early));

  typedef struct {
    logic  exp_reg;
    logic  exp_early;
    string tag;
  } item_t;

  item_t sb_q[$];
  logic [2:0] model_hist = 3'b000;
  string cur_tag = "R1";
  bit lag_valid = 0;
  logic prev_early_sh, prev_early_pg;

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: expected values come from the sliding-window model
  task automatic send(input logic b);
    item_t it;
    @(negedge clk);
    it.exp_reg   = (model_hist == 3'b110);
    it.exp_early = ({model_hist[1:0], b} == 3'b110);
    it.tag       = cur_tag;
    sb_q.push_back(it);
    bit_i = b;
    model_hist = {model_hist[1:0], b};
  endtask

  task automatic send_str(input string s);
    for (int i = 0; i < s.len(); i++) send(s[i] == "1");
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    #1.5;
    rst_ni = 1'b0;
    bit_i = 1'b0;
    model_hist = 3'b000;
    @(negedge clk);
    #1;
    // R1: both styles quiet while reset is held
    check("R1", "reg shift in reset", m_sh_reg, 1'b0);
    check("R1", "early shift in reset", m_sh_early, 1'b0);
    check("R1", "reg prog in reset", m_pg_reg, 1'b0);
    check("R1", "early prog in reset", m_pg_early, 1'b0);
    lag_valid = 0;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // monitor: pops one expected item per cycle
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.tag, "registered/shift", m_sh_reg, it.exp_reg);
        check(it.tag, "registered/progress", m_pg_reg, it.exp_reg);
        check(it.tag, "early/shift", m_sh_early, it.exp_early);
        check(it.tag, "early/progress", m_pg_early, it.exp_early);
        // R7: both encodings agree
        check("R7", "encodings agree early", m_sh_early, m_pg_early);
        if (lag_valid) begin
          // R6: registered now equals early one cycle ago
          check("R6", "lag shift", m_sh_reg, prev_early_sh);
          check("R6", "lag progress", m_pg_reg, prev_early_pg);
        end
        prev_early_sh = m_sh_early;
        prev_early_pg = m_pg_early;
        lag_valid = 1;
      end
    end
  end

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog expired, expected run to finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "reg at power-up reset", m_sh_reg, 1'b0);
    check("R1", "early at power-up reset", m_pg_early, 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    cur_tag = "R1"; send_str("10");         // history from reset gives no match
    cur_tag = "R2"; send_str("00111");      // wrong order never matches
    cur_tag = "R3"; send_str("0110");
    cur_tag = "R4"; send_str("00110");
    cur_tag = "R5"; send_str("0110110");
    cur_tag = "R5"; send_str("01110");
    cur_tag = "R8"; send_str("0110101111100");
    cur_tag = "R6"; send_str("1101100");

    // partial 1,1 cut off by reset, then the completing 0
    cur_tag = "R1"; send_str("011");
    repeat (2) @(negedge clk);
    pulse_reset();
    cur_tag = "R1"; send_str("0011");
    cur_tag = "R3"; send_str("0");

    cur_tag = "R7";
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      send(lfsr[0]);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    send_str("000");
    repeat (3) @(negedge clk);
    #2;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule